// File: doc/BRIEF.md
# Presettable Up-Counter with Terminal-Count Reload

This block is a synchronous binary up-counter with a parallel preset. It can run as a plain free-running counter, or it can be set up as a programmable divider. In free-running mode the count wraps from all-ones back to zero. In divider mode, reaching the top value loads the preset again instead of wrapping. A gate input chooses between the two modes. When the gate is held low, which is the resting state a board tie-off would give, the counter wraps.

An active-low terminal-count flag shows the all-ones state. It is decoded combinationally from the count, so several stages can be chained with it. A separate registered divider output pulses for one clock after every wrap or reload. That output is meant for a single stage only and must not be used in a cascade. An explicit load input and a count enable complete the controls. The master reset acts asynchronously.

Top module: `preset_up_counter`

## Requirements
- R1: While `rst_a` is high, `count` is 0, `div_out` is 0 and `tc_n` is 1. This takes effect at once, without waiting for a clock edge.
- R2: With `load_en`=0, `cnt_en`=1 and `count` below all-ones, each rising clock edge adds one to `count`.
- R3: `tc_n` is 0 exactly when every bit of `count` is 1, and it is 1 otherwise, including when `count` is 0.
- R4: With `reload_gate`=0, `cnt_en`=1, `load_en`=0 and `count` at all-ones, the next edge sets `count` to 0.
- R5: With `reload_gate`=1, `cnt_en`=1, `load_en`=0 and `count` at all-ones, the next edge loads `preset` into `count`.
- R6: With `load_en`=1, the next edge loads `preset` into `count`, whatever the values of `cnt_en`, `reload_gate` and the terminal count.
- R7: With `load_en`=0 and `cnt_en`=0, `count` holds its value, and `tc_n` keeps following the held value.
- R8: `div_out` is 1 for exactly the one clock that follows an edge at which a wrap (R4) or a reload (R5) took place, and it is 0 after every other edge.
- R9: With `reload_gate`=1, `cnt_en`=1 and `load_en`=0, `div_out` rises once every 256 minus `preset` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_a | input | 1 | Asynchronous master reset, active high |
| load_en | input | 1 | Parallel load of `preset` on the next edge |
| preset | input | 8 | Preset value used by parallel load and by reload |
| cnt_en | input | 1 | Count enable; the count holds when low |
| reload_gate | input | 1 | 1 = reload at terminal count, 0 = wrap |
| count | output | 8 | Current count |
| tc_n | output | 1 | Terminal count, active low, used for cascading |
| div_out | output | 1 | Registered one-clock divider pulse, single stage only |

## Verification
The bench builds the counter with its default width of 8 bits. At that width a full wrap takes 256 clocks, so complete free-running cycles stay short enough to run several of them and still reach every R4 transition. With 8 bits, reload presets near the top of the range give short divider periods, and those periods are measured directly for R9. Load priority is exercised while the count sits at all-ones with the gate both high and low. An asynchronous reset is pulsed between clock edges to show that R1 does not depend on the clock.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // What the counter does at the coming edge, in priority order.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_INC    = 3'd1,
        ACT_WRAP   = 3'd2,
        ACT_RELOAD = 3'd3,
        ACT_LOAD   = 3'd4
    } cnt_act_e;

endpackage

// File: rtl/tc_detect.sv
module tc_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic         tc_n
);
    // Active-low flag for the all-ones state.
    always_comb begin
        tc_n = ~(&value);
    end
endmodule

// File: rtl/cnt_action.sv
module cnt_action
    import cnt_pkg::*;
(
    input  logic     load_en,
    input  logic     cnt_en,
    input  logic     reload_gate,
    input  logic     tc_n,
    output cnt_act_e act
);
    // Explicit load wins; terminal-count handling only applies while counting.
    always_comb begin
        if (load_en) begin
            act = ACT_LOAD;
        end else if (!cnt_en) begin
            act = ACT_HOLD;
        end else if (!tc_n) begin
            act = reload_gate ? ACT_RELOAD : ACT_WRAP;
        end else begin
            act = ACT_INC;
        end
    end
endmodule

// File: rtl/preset_up_counter.sv
module preset_up_counter
    import cnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_a,
    input  logic         load_en,
    input  logic [W-1:0] preset,
    input  logic         cnt_en,
    input  logic         reload_gate,
    output logic [W-1:0] count,
    output logic         tc_n,
    output logic         div_out
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         div;
    } state_t;

    state_t   st_d, st_q;
    cnt_act_e act;
    logic     tc_n_w;

    tc_detect #(.W(W)) u_tc (
        .value (st_q.cnt),
        .tc_n  (tc_n_w)
    );

    cnt_action u_act (
        .load_en     (load_en),
        .cnt_en      (cnt_en),
        .reload_gate (reload_gate),
        .tc_n        (tc_n_w),
        .act         (act)
    );

    always_comb begin
        st_d     = st_q;
        st_d.div = 1'b0;
        case (act)
            ACT_LOAD:   st_d.cnt = preset;
            ACT_RELOAD: begin
                st_d.cnt = preset;
                st_d.div = 1'b1;
            end
            ACT_WRAP: begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.div = 1'b1;
            end
            ACT_INC:    st_d.cnt = st_q.cnt + ONE;
            default:    st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign tc_n    = tc_n_w;
    assign div_out = st_q.div;

    // R2: normal increment below the top value
    a_r2_increment: assert property (@(posedge clk) disable iff (rst_a)
        (!load_en && cnt_en && tc_n) |=> (count == $past(count) + ONE));
    // R3: zero is never the terminal count
    a_r3_zero_not_tc: assert property (@(posedge clk) disable iff (rst_a)
        (count == '0) |-> tc_n);
    // R4: wrap to zero with the gate low
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst_a)
        (!load_en && cnt_en && !tc_n && !reload_gate) |=> (count == '0));
    // R5: reload of preset with the gate high
    a_r5_reload: assert property (@(posedge clk) disable iff (rst_a)
        (!load_en && cnt_en && !tc_n && reload_gate) |=> (count == $past(preset)));
    // R6: explicit load has priority
    a_r6_load: assert property (@(posedge clk) disable iff (rst_a)
        load_en |=> (count == $past(preset)));
    // R7: hold when disabled
    a_r7_hold: assert property (@(posedge clk) disable iff (rst_a)
        (!load_en && !cnt_en) |=> $stable(count));
    // R8: divider pulse only after a terminal-count event
    a_r8_div_cause: assert property (@(posedge clk) disable iff (rst_a)
        (!load_en && cnt_en && !tc_n) |=> div_out);
    a_r8_div_none: assert property (@(posedge clk) disable iff (rst_a)
        (load_en || !cnt_en || tc_n) |=> !div_out);
endmodule

// File: tb/sim_preset_up_counter.sv
module sim_preset_up_counter;
    logic       clk = 1'b0;
    logic       rst_a = 1'b1;
    logic       load_en = 1'b0;
    logic [7:0] preset = 8'h00;
    logic       cnt_en = 1'b0;
    logic       reload_gate = 1'b0;
    logic [7:0] count;
    logic       tc_n;
    logic       div_out;

    int checks = 0;
    int failures = 0;

    // reference model state
    int    m_cnt = 0;
    int    m_div = 0;
    string m_tag = "R1";

    always #2 clk = ~clk;

    preset_up_counter u0 (
        .clk(clk), .rst_a(rst_a), .load_en(load_en), .preset(preset),
        .cnt_en(cnt_en), .reload_gate(reload_gate),
        .count(count), .tc_n(tc_n), .div_out(div_out)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural model of the requirements
    always @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            m_cnt = 0; m_div = 0; m_tag = "R1";
        end else if (load_en) begin
            m_cnt = int'(preset); m_div = 0; m_tag = "R6";
        end else if (!cnt_en) begin
            m_div = 0; m_tag = "R7";
        end else if (m_cnt == 255) begin
            m_div = 1;
            if (reload_gate) begin m_cnt = int'(preset); m_tag = "R5"; end
            else begin m_cnt = 0; m_tag = "R4"; end
        end else begin
            m_cnt = m_cnt + 1; m_div = 0; m_tag = "R2";
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        chk(m_tag, int'(count), m_cnt, "count");
        chk("R3", int'(tc_n), (m_cnt == 255) ? 0 : 1, "tc_n");
        chk("R8", int'(div_out), m_div, "div_out");
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic period(input logic [7:0] p);
        int t0;
        int t1;
        int cyc_n;
        preset = p; reload_gate = 1'b1; cnt_en = 1'b1;
        load_en = 1'b1; cyc(1); load_en = 1'b0;
        cyc_n = 0;
        while (!div_out) begin cyc(1); cyc_n++; end
        t0 = cyc_n;
        cyc(1); cyc_n++;
        while (!div_out) begin cyc(1); cyc_n++; end
        t1 = cyc_n;
        chk("R9", t1 - t0, 256 - int'(p), "div period");
    endtask

    initial begin
        fork
            begin
                #3;
                chk("R1", int'(count), 0, "reset count");
                chk("R1", int'(tc_n), 1, "reset tc_n");
                chk("R1", int'(div_out), 0, "reset div_out");
                cyc(2);
                rst_a = 1'b0;
                // R2/R4: free-running over two full wraps
                cnt_en = 1'b1;
                cyc(520);
                // R7: hold at all-ones
                preset = 8'hFF; load_en = 1'b1; cyc(1); load_en = 1'b0;
                cnt_en = 1'b0; cyc(5);
                chk("R7", int'(tc_n), 0, "held tc_n");
                // R6: load wins at terminal count, gate high and low
                reload_gate = 1'b1; cnt_en = 1'b1; preset = 8'h12; load_en = 1'b1;
                cyc(1);
                chk("R6", int'(count), 8'h12, "load over reload");
                preset = 8'hFF; cyc(1);
                reload_gate = 1'b0; preset = 8'h34; cyc(1);
                chk("R6", int'(count), 8'h34, "load over wrap");
                load_en = 1'b0;
                // R5/R9: divider periods
                period(8'hF0);
                period(8'hFA);
                period(8'hFE);
                period(8'h80);
                // R1: asynchronous reset between edges
                cyc(3);
                #1 rst_a = 1'b1;
                #0.5;
                chk("R1", int'(count), 0, "async count");
                chk("R1", int'(tc_n), 1, "async tc_n");
                chk("R1", int'(div_out), 0, "async div_out");
                cyc(2);
                rst_a = 1'b0;
                cyc(10);
            end
            begin
                #400000;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule